// File: doc/BRIEF.md
# Maskable Input-Line Interrupt Controller

This block gathers interrupt sources for a processor core and turns them into a single request line. There are three kinds of source. The first is a maskable group made up of a keyboard-down line and a set of input-register lines. The second is one always-live high-priority line. The third is two active-low unmaskable pins. The core can mask and unmask the maskable group, force the group to re-arm, and acknowledge a pending request.

The maskable group is level-based and uses a one-shot arm. A request is taken when at least one line of the group is high, the group is armed and the group is unmasked. Taking a request disarms the group. The group arms again only after every line in it has been low in the same cycle, or when the re-arm command is given. A line that rises while the group is masked therefore produces a request on unmask only if it is still high at that moment.

The high-priority line interrupts on its rising edge. Each unmaskable pin interrupts on its falling edge and also masks the maskable group. One of the two pins also sets a sticky module-pulled status flag.

Top module: `intline_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` and `mod_pulled_o` are 0, the maskable group is unmasked and armed, and a maskable line going high raises `irq_o` after the next clock edge.
- R2: While masked, a high maskable line (`kbd_down_i` or any bit of `in_lines_i`) never raises `irq_o`.
- R3: A mask-on pulse unmasks in its own cycle. If a maskable line is high and the group is armed, `irq_o` rises after that edge. If every maskable line went low before the mask-on pulse, no request follows.
- R4: After a maskable request, no further maskable request is taken while any maskable line stays high. Once all of them are low in one cycle, the group re-arms.
- R5: A re-arm pulse arms the group in its own cycle, so a maskable line that is still high raises a new request after that edge (when unmasked).
- R6: A falling edge on `nmi_mod_n_i` raises `irq_o`, masks the maskable group and sets `mod_pulled_o`. The flag stays set until reset.
- R7: A falling edge on `nmi_aux_n_i` raises `irq_o` and masks the maskable group, but leaves `mod_pulled_o` unchanged.
- R8: A rising edge on `hp_line_i` raises `irq_o` even while masked. Holding the line high does not raise a second request.
- R9: `irq_o` stays high until `irq_ack_i` is pulsed and drops after that edge. A new event in the same cycle as the acknowledge keeps it high.
- R10: When mask-off and mask-on are pulsed in the same cycle, the group ends up masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_on_i | input | 1 | One-cycle pulse: unmask the maskable group |
| mask_off_i | input | 1 | One-cycle pulse: mask the maskable group |
| rearm_i | input | 1 | One-cycle pulse: force the maskable group to re-arm |
| irq_ack_i | input | 1 | Core acknowledge of the pending request |
| kbd_down_i | input | 1 | Keyboard-down level, maskable |
| in_lines_i | input | NUM_LINES | Input-register levels, maskable |
| hp_line_i | input | 1 | High-priority line, rising edge always interrupts |
| nmi_mod_n_i | input | 1 | Unmaskable pin, active low, sets status flag |
| nmi_aux_n_i | input | 1 | Unmaskable pin, active low, no status |
| irq_o | output | 1 | Interrupt request to the core |
| mod_pulled_o | output | 1 | Sticky module-pulled status flag |

## Verification
The hardest states to reach are the ones where the arm flag and the line levels disagree. Examples are a line that stays high across an acknowledge while a second line joins it, and a line that is raised and then dropped while the group is masked. The stimulus holds levels steady across several acknowledge cycles and across mask/unmask pulses, then forces re-arm with the command while a line is still high. It also lands an acknowledge in the same cycle as a fresh high-priority edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef struct packed {
        logic masked;
        logic pend;
        logic mp;
    } pend_st_t;

    typedef struct packed {
        logic armed;
    } arm_st_t;

endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
    parameter int WIDTH   = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] ev_o
);
    // Idle level of each line; the reset value of the history register.
    localparam logic [WIDTH-1:0] IDLE_LVL = {WIDTH{FALLING}};

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= prev_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign ev_o = prev_q & ~lvl_i;
        end else begin : g_rise
            assign ev_o = ~prev_q & lvl_i;
        end
    endgenerate

endmodule

// File: rtl/intc_arm_unit.sv
module intc_arm_unit #(
    parameter int SRC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             mask_eff_i,
    input  logic             rearm_i,
    output logic             fire_o
);
    import intc_pkg::*;

    arm_st_t st_d, st_q;
    logic    any_high;
    logic    arm_eff;

    always_comb begin
        any_high = |src_i;
        arm_eff  = st_q.armed | rearm_i;
        fire_o   = arm_eff & any_high & ~mask_eff_i;
        st_d     = st_q;
        if (fire_o)         st_d.armed = 1'b0;
        else if (!any_high) st_d.armed = 1'b1;
        else if (rearm_i)   st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{armed: 1'b1};
        else        st_q <= st_d;
    end

    AST_NO_FIRE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !rearm_i) |-> !fire_o); // R4
    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !st_q.armed); // R4
    AST_LOW_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> st_q.armed); // R4

endmodule

// File: rtl/intc_pend_unit.sv
module intc_pend_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic off_i,
    input  logic ack_i,
    input  logic mfire_i,
    input  logic hp_ev_i,
    input  logic mod_ev_i,
    input  logic aux_ev_i,
    output logic mask_eff_o,
    output logic irq_o,
    output logic mp_o
);
    import intc_pkg::*;

    pend_st_t st_d, st_q;
    logic     nmi_ev;
    logic     any_ev;

    always_comb begin
        nmi_ev     = mod_ev_i | aux_ev_i;
        any_ev     = nmi_ev | hp_ev_i | mfire_i;
        // Off wins over on; both are applied in their own cycle.
        mask_eff_o = off_i | (st_q.masked & ~on_i);
        st_d        = st_q;
        st_d.masked = mask_eff_o | nmi_ev;
        st_d.pend   = (st_q.pend & ~ack_i) | any_ev;
        st_d.mp     = st_q.mp | mod_ev_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{masked: 1'b0, pend: 1'b0, mp: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pend;
    assign mp_o  = st_q.mp;

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i && !any_ev) |=> !irq_o); // R9
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o); // R9
    AST_MP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mp_o |=> mp_o); // R6
    AST_NMI_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ev |=> st_q.masked); // R7
    AST_OFF_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> st_q.masked); // R10
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.masked && !on_i) |-> !mfire_i); // R2

endmodule

// File: rtl/intline_irq_ctrl.sv
module intline_irq_ctrl #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_on_i,
    input  logic                 mask_off_i,
    input  logic                 rearm_i,
    input  logic                 irq_ack_i,
    input  logic                 kbd_down_i,
    input  logic [NUM_LINES-1:0] in_lines_i,
    input  logic                 hp_line_i,
    input  logic                 nmi_mod_n_i,
    input  logic                 nmi_aux_n_i,
    output logic                 irq_o,
    output logic                 mod_pulled_o
);
    localparam int SRC_W = NUM_LINES + 1;

    logic [SRC_W-1:0] msk_src;
    logic             mask_eff;
    logic             mfire;
    logic             hp_ev;
    logic [1:0]       nmi_ev;

    assign msk_src = {kbd_down_i, in_lines_i};

    intc_edge_det #(.WIDTH(1), .FALLING(1'b0)) u_hp_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (hp_line_i),
        .ev_o  (hp_ev)
    );

    intc_edge_det #(.WIDTH(2), .FALLING(1'b1)) u_nmi_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({nmi_aux_n_i, nmi_mod_n_i}),
        .ev_o  (nmi_ev)
    );

    intc_arm_unit #(.SRC_W(SRC_W)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (msk_src),
        .mask_eff_i (mask_eff),
        .rearm_i    (rearm_i),
        .fire_o     (mfire)
    );

    intc_pend_unit u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_i       (mask_on_i),
        .off_i      (mask_off_i),
        .ack_i      (irq_ack_i),
        .mfire_i    (mfire),
        .hp_ev_i    (hp_ev),
        .mod_ev_i   (nmi_ev[0]),
        .aux_ev_i   (nmi_ev[1]),
        .mask_eff_o (mask_eff),
        .irq_o      (irq_o),
        .mp_o       (mod_pulled_o)
    );

    AST_HP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hp_line_i) |=> irq_o); // R8
    AST_MOD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_mod_n_i) |=> (irq_o && mod_pulled_o)); // R6

endmodule

// File: tb/intline_irq_ctrl_tb_top.sv
module intline_irq_ctrl_tb_top;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          on_c, off_c, rearm_c, ack_c;
    logic          kbd;
    logic [NL-1:0] lines;
    logic          hp, mod_n, aux_n;
    logic          irq, mp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    intline_irq_ctrl #(.NUM_LINES(NL)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_on_i    (on_c),
        .mask_off_i   (off_c),
        .rearm_i      (rearm_c),
        .irq_ack_i    (ack_c),
        .kbd_down_i   (kbd),
        .in_lines_i   (lines),
        .hp_line_i    (hp),
        .nmi_mod_n_i  (mod_n),
        .nmi_aux_n_i  (aux_n),
        .irq_o        (irq),
        .mod_pulled_o (mp)
    );

    // Monitor: after each rising edge, compare against the scoreboard.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if ({irq, mp} !== e) begin
                n_fail++;
                $display("FAIL %s: irq/mp actual %b%b expected %b%b", t, irq, mp, e[1], e[0]);
            end
        end
    end

    // Driver: called at a falling edge, applies pulses and queues the result.
    task automatic step(input logic on, input logic off, input logic ra, input logic ak,
                        input logic e_irq, input logic e_mp, input string t);
        on_c = on; off_c = off; rearm_c = ra; ack_c = ak;
        exp_q.push_back({e_irq, e_mp});
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; on_c = 0; off_c = 0; rearm_c = 0; ack_c = 0;
        kbd = 0; lines = '0; hp = 0; mod_n = 1; aux_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0, 0,0, "R1 reset state");
        kbd = 1;
        step(0,0,0,0, 1,0, "R1 unmasked armed after reset");
        step(0,0,0,1, 0,0, "R9 ack drops request");
        lines[2] = 1;
        step(0,0,0,0, 0,0, "R4 no rearm while line high");
        kbd = 0; lines = '0;
        step(0,0,0,0, 0,0, "R4 all low rearms silently");
        lines[2] = 1;
        step(0,0,0,0, 1,0, "R4 new request after rearm");
        step(0,0,0,0, 1,0, "R9 request holds without ack");
        step(0,0,0,1, 0,0, "R9 ack clears");
        lines = '0;
        step(0,0,0,0, 0,0, "R4 lines low");
        // masking
        step(0,1,0,0, 0,0, "R2 mask off");
        kbd = 1;
        step(0,0,0,0, 0,0, "R2 masked kbd high");
        step(0,0,0,0, 0,0, "R2 masked kbd held");
        kbd = 0;
        step(0,0,0,0, 0,0, "R2 kbd dropped");
        step(1,0,0,0, 0,0, "R3 unmask after line dropped");
        step(0,1,0,0, 0,0, "R3 mask again");
        kbd = 1;
        step(0,0,0,0, 0,0, "R2 masked kbd high again");
        step(1,0,0,0, 1,0, "R3 unmask with line still high");
        step(0,0,0,1, 0,0, "R9 ack");
        // forced re-arm
        step(0,0,1,0, 1,0, "R5 rearm with line high");
        step(0,0,0,1, 0,0, "R9 ack after rearm");
        kbd = 0;
        step(0,0,0,0, 0,0, "R4 idle");
        // simultaneous mask commands
        step(1,1,0,0, 0,0, "R10 on and off together");
        kbd = 1;
        step(0,0,0,0, 0,0, "R10 ends masked");
        kbd = 0;
        step(1,0,0,0, 0,0, "R3 unmask idle");
        // high-priority line
        step(0,1,0,0, 0,0, "R8 mask off");
        hp = 1;
        step(0,0,0,0, 1,0, "R8 hp edge while masked");
        step(0,0,0,1, 0,0, "R8 held hp no second request");
        hp = 0;
        step(1,0,0,0, 0,0, "R8 hp low, unmask");
        // aux unmaskable pin
        aux_n = 0;
        step(0,0,0,0, 1,0, "R7 aux pin request no status");
        step(0,0,0,1, 0,0, "R7 ack while aux held");
        aux_n = 1; kbd = 1;
        step(0,0,0,0, 0,0, "R7 aux left group masked");
        kbd = 0;
        step(1,0,0,0, 0,0, "R7 unmask");
        // module-pulled pin
        mod_n = 0;
        step(0,0,0,0, 1,1, "R6 mod pin request and status");
        step(0,0,0,1, 0,1, "R6 ack, status sticky");
        mod_n = 1; kbd = 1;
        step(0,0,0,0, 0,1, "R6 mod pin left group masked");
        kbd = 0;
        step(1,0,0,0, 0,1, "R6 unmask, status stays");
        // ack colliding with a new event
        lines[0] = 1;
        step(0,0,0,0, 1,1, "R1 line request");
        hp = 1;
        step(0,0,0,1, 1,1, "R9 new event beats ack");
        step(0,0,0,1, 0,1, "R9 second ack clears");
        hp = 0; lines = '0;
        step(0,0,0,0, 0,1, "R9 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule